// File: doc/BRIEF.md
# Event Timer Channel with Compare Output

This block is a single timer/counter channel. It advances one count register from one of several event sources: a free-running tick enable, edges of a primary input, two-phase encoder decoding of the primary and secondary inputs, edges of the primary input with the secondary input giving the direction, or the tick enable gated by the primary input level. The gated source measures how long the primary input is held active.

A compare value and a reload value are written through a small register port. When the count meets the compare value, the channel can reload at once. It can also run past the compare value and reload only when the count rolls over. The channel can repeat, or it can stop after one terminal event. On a compare hit, an output flag is set, cleared or toggled, which produces square waves, PWM or pulse trains. Edges of the secondary input can latch the current count into a capture register. Both inputs and the output have programmable polarity.

Both external inputs pass through a synchronizer. The tick enable is taken directly. Reset is asynchronous and active low, and it is expected to be released synchronously to the clock.

Top module: `tmr_channel`

## Requirements
- R1: After reset, count and capture are 0, the compare register holds all ones, the reload register holds 0, both interrupt flags are 0 and out_flag is 0.
- R2: Register writes use wr_addr 0 for control, 1 for compare, 2 for reload, 3 for count and 4 for status. Control bits [2:0] select the source. Source 1 counts up by one on each clock with tick_en high, and holds the count while tick_en is low.
- R3: Source 2 counts up on primary input edges. The sensitivity comes from control bits [4:3]: 01 selects rising edges, 10 falling edges and 11 both edges.
- R4: Source 3 decodes the primary (A) and secondary (B) inputs as a two-phase encoder. It counts up by one on each transition of the sequence AB = 00, 10, 11, 01, 00 and down by one on each transition of the reverse sequence.
- R5: Source 4 steps on primary edges selected as in R3. It counts up while the secondary input is 0 and down while it is 1.
- R6: Source 5 counts up on each clock where tick_en is high and the synchronized primary input is active. A primary pulse of N clocks, with tick_en held high, adds exactly N.
- R7: With control bit 6 at 0, a step taken while count equals compare loads the reload value and sets cmp_irq.
- R8: With control bit 6 at 1, a step at the compare value sets cmp_irq and the count keeps moving. The reload value is loaded only when an up step leaves all ones or a down step leaves zero.
- R9: With control bit 5 at 1, counting stops after the first reload event. Any write to the control register restarts it.
- R10: When control bit 12 is 1, a secondary edge selected by control bits [14:13], coded as in R3, copies the current count into capture and sets cap_irq.
- R11: Control bits 10 and 11 invert the primary and secondary inputs before edge detection and gating.
- R12: On a compare hit, control bits [8:7] set (01), clear (10) or toggle (11) the internal flag. out_flag equals that flag XOR control bit 9.
- R13: Writing status with bit 0 at 1 clears cmp_irq, and writing it with bit 1 at 1 clears cap_irq. Otherwise both flags hold. A write to count takes effect at that clock edge and leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled internal count enable |
| pri_in | input | 1 | Primary external input, asynchronous |
| sec_in | input | 1 | Secondary external input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current count |
| capture | output | CNT_W | Captured count |
| out_flag | output | 1 | Compare output after polarity |
| cmp_irq | output | 1 | Sticky compare flag |
| cap_irq | output | 1 | Sticky capture flag |

## Verification
The bench uses the default parameters: a 16-bit count and a two-stage synchronizer. With 16 bits, rollover is reached by writing the count to 0xFFFE and applying two ticks. The fixed two-stage synchronizer means a gated pulse of N clocks must add exactly N, and every edge can be checked after a short settle. Small compare values of 3 to 5 keep reload, one-shot stop and output actions only a few ticks away.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W = 15;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CMP  = 3'd1;
  localparam logic [2:0] A_RLD  = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  typedef enum logic [2:0] {
    SRC_IDLE = 3'd0,
    SRC_TICK = 3'd1,
    SRC_EDGE = 3'd2,
    SRC_QUAD = 3'd3,
    SRC_DIR  = 3'd4,
    SRC_GATE = 3'd5
  } src_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  typedef struct packed {
    logic [1:0] cap_sel;
    logic       cap_en;
    logic       sec_inv;
    logic       pri_inv;
    logic       out_inv;
    logic [1:0] out_act;
    logic       wrap;
    logic       oneshot;
    logic [1:0] edge_sel;
    logic [2:0] src;
  } ctrl_t;

  function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prev);
    edge_hit = (sel[0] & cur & ~prev) | (sel[1] & ~cur & prev);
  endfunction
endpackage

// File: rtl/tmr_insync.sv
module tmr_insync #(
  parameter int STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic inv,
  output logic lvl,
  output logic lvl_prev
);
  logic [STG-1:0] sh_q;
  logic [STG-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STG-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign lvl = sh_q[STG-1] ^ inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl;
  end
endmodule

// File: rtl/tmr_evt.sv
module tmr_evt
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] src,
  input  logic [1:0] edge_sel,
  input  logic       tick,
  input  logic       a,
  input  logic       a_prev,
  input  logic       b,
  input  logic       b_prev,
  output logic       up,
  output logic       dn
);
  logic a_edge;
  logic quad_move;

  assign a_edge    = edge_hit(edge_sel, a, a_prev);
  assign quad_move = (a ^ a_prev) ^ (b ^ b_prev);

  always_comb begin
    up = 1'b0;
    dn = 1'b0;
    unique case (src)
      SRC_TICK: up = tick;
      SRC_EDGE: up = a_edge;
      SRC_QUAD: begin
        up = quad_move & (a ^ b_prev);
        dn = quad_move & ~(a ^ b_prev);
      end
      SRC_DIR: begin
        up = a_edge & ~b;
        dn = a_edge & b;
      end
      SRC_GATE: up = tick & a;
      default: ;
    endcase
  end

  // R4
  quad_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_QUAD && (up || dn)) |-> ((a != a_prev) != (b != b_prev)));

  // R5
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up, dn}));
endmodule

// File: rtl/tmr_outflag.sv
module tmr_outflag
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic [1:0] act,
  input  logic       inv,
  output logic       out_flag
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (hit) begin
      unique case (act)
        ACT_SET: flag_d = 1'b1;
        ACT_CLR: flag_d = 1'b0;
        ACT_TOG: flag_d = ~flag_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign out_flag = flag_q ^ inv;

  // R12
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_TOG) |=> (flag_q != $past(flag_q)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             pri_in,
  input  logic             sec_in,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             out_flag,
  output logic             cmp_irq,
  output logic             cap_irq
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO = {CNT_W{1'b0}};

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d, rld_q, rld_d, cnt_q, cnt_d, cap_q, cap_d;
  logic             cmp_irq_q, cmp_irq_d, cap_irq_q, cap_irq_d, done_q, done_d;

  logic [1:0] raw_in, inv_in, lvl, lvl_prev;
  assign raw_in = {sec_in, pri_in};

  always_comb begin
    inv_in = {ctrl_q.sec_inv, ctrl_q.pri_inv};
  end

  for (genvar i = 0; i < 2; i++) begin : g_sync
    tmr_insync #(.STG(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw_in[i]), .inv(inv_in[i]),
      .lvl(lvl[i]), .lvl_prev(lvl_prev[i])
    );
  end

  logic step_up, step_dn;
  tmr_evt u_evt (
    .clk(clk), .rst_n(rst_n), .src(ctrl_q.src), .edge_sel(ctrl_q.edge_sel),
    .tick(tick_en), .a(lvl[0]), .a_prev(lvl_prev[0]), .b(lvl[1]), .b_prev(lvl_prev[1]),
    .up(step_up), .dn(step_dn)
  );

  logic ctrl_wr, cmp_wr, rld_wr, cnt_wr, st_wr;
  logic step_any, at_cmp, hit, roll, reinit, cap_hit;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == A_CTRL);
    cmp_wr  = wr_en && (wr_addr == A_CMP);
    rld_wr  = wr_en && (wr_addr == A_RLD);
    cnt_wr  = wr_en && (wr_addr == A_CNT);
    st_wr   = wr_en && (wr_addr == A_STAT);

    step_any = (step_up | step_dn) & ~done_q;
    at_cmp   = (cnt_q == cmp_q);
    hit      = step_any & at_cmp;
    roll     = (step_up & (cnt_q == ALL1)) | (step_dn & (cnt_q == ZERO));
    reinit   = step_any & (ctrl_q.wrap ? roll : at_cmp);
    cap_hit  = ctrl_q.cap_en & edge_hit(ctrl_q.cap_sel, lvl[1], lvl_prev[1]);
  end

  always_comb begin
    ctrl_d = ctrl_wr ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
    cmp_d  = cmp_wr ? wr_data : cmp_q;
    rld_d  = rld_wr ? wr_data : rld_q;

    if (cnt_wr)        cnt_d = wr_data;
    else if (reinit)   cnt_d = rld_q;
    else if (step_any) cnt_d = step_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    else               cnt_d = cnt_q;

    if (ctrl_wr)                      done_d = 1'b0;
    else if (reinit && ctrl_q.oneshot) done_d = 1'b1;
    else                              done_d = done_q;

    cap_d     = cap_hit ? cnt_q : cap_q;
    cmp_irq_d = hit | (cmp_irq_q & ~(st_wr & wr_data[0]));
    cap_irq_d = cap_hit | (cap_irq_q & ~(st_wr & wr_data[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cmp_q     <= ALL1;
      rld_q     <= ZERO;
      cnt_q     <= ZERO;
      cap_q     <= ZERO;
      cmp_irq_q <= 1'b0;
      cap_irq_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      cmp_q     <= cmp_d;
      rld_q     <= rld_d;
      cnt_q     <= cnt_d;
      cap_q     <= cap_d;
      cmp_irq_q <= cmp_irq_d;
      cap_irq_q <= cap_irq_d;
      done_q    <= done_d;
    end
  end

  tmr_outflag u_out (
    .clk(clk), .rst_n(rst_n), .hit(hit), .act(ctrl_q.out_act),
    .inv(ctrl_q.out_inv), .out_flag(out_flag)
  );

  assign count   = cnt_q;
  assign capture = cap_q;
  assign cmp_irq = cmp_irq_q;
  assign cap_irq = cap_irq_q;

  // R7
  reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_any && at_cmp && !ctrl_q.wrap && !cnt_wr) |=> (cnt_q == $past(rld_q)));

  // R9
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cnt_wr) |=> $stable(cnt_q));

  // R10
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (cap_q == $past(cnt_q)) && cap_irq_q);

  // R13
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_irq_q && !(st_wr && wr_data[0])) |=> cmp_irq_q);
endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, pri_in = 1'b0, sec_in = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] count, capture;
  logic        out_flag, cmp_irq, cap_irq;
  int          n_chk = 0, n_fail = 0;
  logic        exp_flag = 1'b0;

  always #2 clk = ~clk;

  tmr_channel dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pri_in(pri_in), .sec_in(sec_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
    .capture(capture), .out_flag(out_flag), .cmp_irq(cmp_irq), .cap_irq(cap_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [15:0] ctl(input logic [2:0] src, input logic [1:0] es,
      input logic os, input logic wrap, input logic [1:0] act, input logic oinv,
      input logic pinv, input logic sinv, input logic cen, input logic [1:0] cs);
    ctl = {1'b0, cs, cen, sinv, pinv, oinv, act, wrap, os, es, src};
  endfunction

  task automatic t_reset();
    chk("R1 count", count, 16'd0);
    chk("R1 capture", capture, 16'd0);
    chk("R1 flags", {13'd0, out_flag, cmp_irq, cap_irq}, 16'd0);
  endtask

  task automatic t_tick();
    wr(3'd0, ctl(3'd1, 2'b00, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00));
    wr(3'd3, 16'd10);
    ticks(7);
    chk("R2 tick count", count, 16'd17);
    repeat (3) @(negedge clk);
    chk("R2 hold without tick", count, 16'd17);
  endtask

  task automatic pri_pulse();
    pri_in = 1'b1; settle();
    pri_in = 1'b0; settle();
  endtask

  task automatic t_edge();
    wr(3'd0, 16'd0); pri_in = 1'b0; settle();
    wr(3'd0, ctl(3'd2, 2'b01, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00));
    wr(3'd3, 16'd0);
    pri_pulse(); pri_pulse();
    chk("R3 rising", count, 16'd2);
    wr(3'd0, ctl(3'd2, 2'b10, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00));
    pri_pulse(); pri_pulse();
    chk("R3 falling", count, 16'd4);
    wr(3'd0, ctl(3'd2, 2'b11, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00));
    pri_pulse(); pri_pulse();
    chk("R3 both", count, 16'd8);
  endtask

  task automatic ab(input logic a, input logic b);
    pri_in = a; sec_in = b; settle();
  endtask

  task automatic t_quad();
    wr(3'd0, 16'd0); ab(0, 0);
    wr(3'd0, ctl(3'd3, 2'b00, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00));
    wr(3'd3, 16'd50);
    ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
    chk("R4 quad up", count, 16'd54);
    ab(0, 1); ab(1, 1);
    chk("R4 quad down", count, 16'd52);
  endtask

  task automatic t_dir();
    wr(3'd0, 16'd0); ab(0, 1);
    wr(3'd0, ctl(3'd4, 2'b01, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00));
    wr(3'd3, 16'd100);
    pri_pulse(); pri_pulse(); pri_pulse();
    chk("R5 down", count, 16'd97);
    sec_in = 1'b0; settle();
    pri_pulse(); pri_pulse();
    chk("R5 up", count, 16'd99);
  endtask

  task automatic t_gate();
    wr(3'd0, 16'd0); ab(0, 0);
    tick_en = 1'b1;
    wr(3'd0, ctl(3'd5, 2'b00, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00));
    wr(3'd3, 16'd0);
    pri_in = 1'b1;
    repeat (6) @(negedge clk);
    pri_in = 1'b0;
    settle();
    tick_en = 1'b0;
    chk("R6 gated width", count, 16'd6);
  endtask

  task automatic t_cmp();
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd5); wr(3'd2, 16'd2);
    wr(3'd0, ctl(3'd1, 2'b00, 0, 0, 2'b11, 0, 0, 0, 0, 2'b00));
    wr(3'd3, 16'd0);
    ticks(6);
    exp_flag = ~exp_flag;
    chk("R7 reload", count, 16'd2);
    chk("R7 cmp_irq", {15'd0, cmp_irq}, 16'd1);
    chk("R12 toggle", {15'd0, out_flag}, {15'd0, exp_flag});
    wr(3'd4, 16'd1);
    chk("R13 w1c cmp", {15'd0, cmp_irq}, 16'd0);
  endtask

  task automatic t_wrap();
    wr(3'd0, ctl(3'd1, 2'b00, 0, 1, 2'b00, 0, 0, 0, 0, 2'b00));
    wr(3'd3, 16'd3);
    ticks(3);
    chk("R8 pass compare", count, 16'd6);
    chk("R8 cmp_irq", {15'd0, cmp_irq}, 16'd1);
    wr(3'd4, 16'd1);
    wr(3'd3, 16'hFFFE);
    ticks(2);
    chk("R8 rollover reload", count, 16'd2);
  endtask

  task automatic t_oneshot();
    wr(3'd1, 16'd3); wr(3'd2, 16'd0);
    wr(3'd0, ctl(3'd1, 2'b00, 1, 0, 2'b00, 0, 0, 0, 0, 2'b00));
    wr(3'd3, 16'd0);
    ticks(10);
    chk("R9 stopped", count, 16'd0);
    wr(3'd0, ctl(3'd1, 2'b00, 1, 0, 2'b00, 0, 0, 0, 0, 2'b00));
    ticks(2);
    chk("R9 restart", count, 16'd2);
  endtask

  task automatic t_out();
    wr(3'd1, 16'd4); wr(3'd2, 16'd0);
    wr(3'd0, ctl(3'd1, 2'b00, 0, 0, 2'b10, 1, 0, 0, 0, 2'b00));
    chk("R12 invert", {15'd0, out_flag}, {15'd0, ~exp_flag});
    wr(3'd3, 16'd0);
    ticks(5);
    exp_flag = 1'b0;
    chk("R12 clear", {15'd0, out_flag}, {15'd0, ~exp_flag});
    wr(3'd0, ctl(3'd1, 2'b00, 0, 0, 2'b01, 1, 0, 0, 0, 2'b00));
    wr(3'd3, 16'd4);
    ticks(1);
    exp_flag = 1'b1;
    chk("R12 set", {15'd0, out_flag}, {15'd0, ~exp_flag});
  endtask

  task automatic t_cap();
    wr(3'd0, 16'd0); ab(0, 0);
    wr(3'd0, ctl(3'd0, 2'b00, 0, 0, 2'b00, 0, 0, 0, 1, 2'b10));
    wr(3'd3, 16'h1234);
    sec_in = 1'b1; settle();
    chk("R10 no capture on rise", capture, 16'd0);
    chk("R10 no cap_irq on rise", {15'd0, cap_irq}, 16'd0);
    sec_in = 1'b0; settle();
    chk("R10 captured", capture, 16'h1234);
    chk("R10 cap_irq", {15'd0, cap_irq}, 16'd1);
    wr(3'd3, 16'h0055);
    chk("R13 count forced", count, 16'h0055);
    chk("R13 cap_irq kept", {15'd0, cap_irq}, 16'd1);
    wr(3'd4, 16'd2);
    chk("R13 w1c cap", {15'd0, cap_irq}, 16'd0);
  endtask

  task automatic t_pol();
    wr(3'd0, 16'd0); ab(1, 0);
    wr(3'd0, ctl(3'd2, 2'b01, 0, 0, 2'b00, 0, 1, 0, 0, 2'b00));
    settle();
    wr(3'd3, 16'd0);
    pri_in = 1'b0; settle();
    pri_in = 1'b1; settle();
    chk("R11 inverted primary", count, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick();
    t_edge();
    t_quad();
    t_dir();
    t_gate();
    t_cmp();
    t_wrap();
    t_oneshot();
    t_out();
    t_cap();
    t_pol();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule